// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block carries 36-bit words from a producer running on one clock to a consumer running on another. The producer pushes a word on a rising edge of its own clock by raising the write enable. The consumer pulls words in arrival order on rising edges of its clock. The two clocks may be unrelated, or they may be literally the same net. In that case a push and a pull can land on one edge.

The writer sees two status outputs: one for no room left, and one for room down to a chosen margin. The reader sees two more: one for nothing stored, and one for contents down to a chosen margin. Both margins are captured while reset is held. Read and write positions cross between the domains as Gray-coded counters through a chain of synchronizer flops. Each flag is then recomputed and registered in the domain that consumes it. Storage is a register array with 64 entries by default.

Top module: `dcx_fifo`

## Requirements
- R1: Words leave the read port in the exact order they were accepted at the write port, up to 64 words of 36 bits held at once.
- R2: A word is accepted only on a rising `wclk` edge where `wen_i` is 1 and `full_o` is 0. A write attempted while `full_o` is 1 changes neither the contents nor the order of the words later read.
- R3: A read is accepted only on a rising `rclk` edge where `ren_i` is 1 and `empty_o` is 0, and the word appears on `rdata_o` at that same edge. A read attempted while `empty_o` is 1 leaves `rdata_o` and the read position unchanged.
- R4: `full_o` is 1 exactly when the writer's view of the stored count is 64. It returns to 0 once reads have crossed into the write domain.
- R5: `afull_o` is 1 when the free space seen by the writer is at most the almost-full margin, and 0 otherwise.
- R6: `empty_o` is 1 when the reader's view of the stored count is 0. `aempty_o` is 1 when that count is at most the almost-empty margin.
- R7: Both margins are sampled from `af_thr_i` and `ae_thr_i` on clock edges while `rst_n` is low, and on the first edge after release. A sampled value of 0 selects the default margin of 8.
- R8: While and after reset, before any write, `empty_o` and `aempty_o` read 1 and `full_o` and `afull_o` read 0.
- R9: Positions cross domains in Gray code, so a crossing position changes at most one bit per edge. A change made by the far side reaches the flags within a few edges of the observing clock.
- R10: With `rclk` and `wclk` driven by the same edge, a write and a read enabled together on one edge are both accepted, and data order holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| af_thr_i | input | 6 | Almost-full margin in free words, sampled during reset (0 = default 8) |
| ae_thr_i | input | 6 | Almost-empty margin in stored words, sampled during reset (0 = default 8) |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 36 | Write data |
| full_o | output | 1 | No free entry, write domain |
| afull_o | output | 1 | Free entries at or below margin, write domain |
| ren_i | input | 1 | Read enable |
| rdata_o | output | 36 | Registered read data |
| empty_o | output | 1 | No stored entry, read domain |
| aempty_o | output | 1 | Stored entries at or below margin, read domain |

## Verification
The functions that can coincide are an accepted write and an accepted read on one edge. The bench provokes this by driving `rclk` from the write clock and holding both enables high for a burst, with a few words already stored. The case is judged on three things. Every cycle must return the next expected word, no read may be refused by a stale empty view, and the final occupancy flags must match the unchanged count of six.

// File: rtl/dcx_fifo_pkg.sv
`timescale 1ns/1ps
package dcx_fifo_pkg;
   localparam int PTR_MAX = 16;
   typedef logic [PTR_MAX-1:0] ptr_t;

   function automatic ptr_t bin2gray(input ptr_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_t gray2bin(input ptr_t g);
      ptr_t b;
      for (int i = 0; i < PTR_MAX; i++) b[i] = ^(g >> i);
      return b;
   endfunction
endpackage

// File: rtl/dcx_fifo_sync.sv
`timescale 1ns/1ps
module dcx_fifo_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st[s] <= '0;
         else if (s == 0) st[s] <= d_i;
         else             st[s] <= st[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = st[STAGES-1];
endmodule

// File: rtl/dcx_fifo_wside.sv
`timescale 1ns/1ps
module dcx_fifo_wside
   import dcx_fifo_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int THR_DEF = 8,
   parameter int SYNC_N  = 2,
   localparam int PTR_W  = ADDR_W + 1,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              wen_i,
   input  logic [ADDR_W-1:0] thr_i,
   input  logic [PTR_W-1:0]  rgray_i,
   output logic              wacc_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [PTR_W-1:0]  wgray_o,
   output logic              full_o,
   output logic              afull_o
);
   logic [PTR_W-1:0]  rgray_s, rbin, wbin, wbin_nxt, used, free;
   logic [ADDR_W-1:0] thr_q;
   logic              in_rst;

   dcx_fifo_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_rsync (
      .clk(wclk), .rst_n(rst_n), .d_i(rgray_i), .q_o(rgray_s));

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) in_rst <= 1'b1;
      else        in_rst <= 1'b0;
   end

   always_ff @(posedge wclk) begin
      if (in_rst) thr_q <= (thr_i == '0) ? ADDR_W'(THR_DEF) : thr_i;
   end

   assign rbin     = PTR_W'(gray2bin(ptr_t'(rgray_s)));
   assign wacc_o   = wen_i & ~full_o;
   assign wbin_nxt = wbin + PTR_W'(wacc_o);
   assign used     = wbin_nxt - rbin;
   assign free     = PTR_W'(DEPTH) - used;
   assign waddr_o  = wbin[ADDR_W-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray_o <= '0;
         full_o  <= 1'b0;
         afull_o <= 1'b0;
      end else begin
         wbin    <= wbin_nxt;
         wgray_o <= PTR_W'(bin2gray(ptr_t'(wbin_nxt)));
         full_o  <= (used == PTR_W'(DEPTH));
         afull_o <= (free <= {1'b0, thr_q});
      end
   end
endmodule

// File: rtl/dcx_fifo_rside.sv
`timescale 1ns/1ps
module dcx_fifo_rside
   import dcx_fifo_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int THR_DEF = 8,
   parameter int SYNC_N  = 2,
   localparam int PTR_W  = ADDR_W + 1
) (
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              ren_i,
   input  logic [ADDR_W-1:0] thr_i,
   input  logic [PTR_W-1:0]  wgray_i,
   output logic              racc_o,
   output logic [ADDR_W-1:0] raddr_o,
   output logic [PTR_W-1:0]  rgray_o,
   output logic              empty_o,
   output logic              aempty_o
);
   logic [PTR_W-1:0]  wgray_s, wbin, rbin, rbin_nxt, used;
   logic [ADDR_W-1:0] thr_q;
   logic              in_rst;

   dcx_fifo_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_wsync (
      .clk(rclk), .rst_n(rst_n), .d_i(wgray_i), .q_o(wgray_s));

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) in_rst <= 1'b1;
      else        in_rst <= 1'b0;
   end

   always_ff @(posedge rclk) begin
      if (in_rst) thr_q <= (thr_i == '0) ? ADDR_W'(THR_DEF) : thr_i;
   end

   assign wbin     = PTR_W'(gray2bin(ptr_t'(wgray_s)));
   assign racc_o   = ren_i & ~empty_o;
   assign rbin_nxt = rbin + PTR_W'(racc_o);
   assign used     = wbin - rbin_nxt;
   assign raddr_o  = rbin[ADDR_W-1:0];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray_o  <= '0;
         empty_o  <= 1'b1;
         aempty_o <= 1'b1;
      end else begin
         rbin     <= rbin_nxt;
         rgray_o  <= PTR_W'(bin2gray(ptr_t'(rbin_nxt)));
         empty_o  <= (used == '0);
         aempty_o <= (used <= {1'b0, thr_q});
      end
   end
endmodule

// File: rtl/dcx_fifo_mem.sv
`timescale 1ns/1ps
module dcx_fifo_mem #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              wclk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rclk,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] arr [DEPTH];

   always_ff @(posedge wclk) begin
      if (we_i) arr[waddr_i] <= wdata_i;
   end

   always_ff @(posedge rclk) begin
      if (re_i) rdata_o <= arr[raddr_i];
   end
endmodule

// File: rtl/dcx_fifo.sv
`timescale 1ns/1ps
module dcx_fifo #(
   parameter int DATA_W  = 36,
   parameter int ADDR_W  = 6,
   parameter int THR_DEF = 8,
   parameter int SYNC_N  = 2,
   localparam int PTR_W  = ADDR_W + 1,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] af_thr_i,
   input  logic [ADDR_W-1:0] ae_thr_i,
   input  logic              wen_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              full_o,
   output logic              afull_o,
   input  logic              ren_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              empty_o,
   output logic              aempty_o
);
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("dcx_fifo: ADDR_W out of range");
   end
   if (THR_DEF < 1 || THR_DEF >= DEPTH) begin : g_bad_thr
      $error("dcx_fifo: THR_DEF must lie in 1..DEPTH-1");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("dcx_fifo: SYNC_N must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dcx_fifo: DATA_W must be positive");
   end

   logic              wacc, racc;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PTR_W-1:0]  wgray, rgray;

   dcx_fifo_wside #(.ADDR_W(ADDR_W), .THR_DEF(THR_DEF), .SYNC_N(SYNC_N)) u_wside (
      .wclk(wclk), .rst_n(rst_n), .wen_i(wen_i), .thr_i(af_thr_i),
      .rgray_i(rgray), .wacc_o(wacc), .waddr_o(waddr), .wgray_o(wgray),
      .full_o(full_o), .afull_o(afull_o));

   dcx_fifo_rside #(.ADDR_W(ADDR_W), .THR_DEF(THR_DEF), .SYNC_N(SYNC_N)) u_rside (
      .rclk(rclk), .rst_n(rst_n), .ren_i(ren_i), .thr_i(ae_thr_i),
      .wgray_i(wgray), .racc_o(racc), .raddr_o(raddr), .rgray_o(rgray),
      .empty_o(empty_o), .aempty_o(aempty_o));

   dcx_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk(wclk), .we_i(wacc), .waddr_i(waddr), .wdata_i(wdata_i),
      .rclk(rclk), .re_i(racc), .raddr_i(raddr), .rdata_o(rdata_o));
endmodule

// File: rtl/dcx_fifo_chk.sv
`timescale 1ns/1ps
module dcx_fifo_chk #(
   parameter int DATA_W = 36,
   parameter int PTR_W  = 7
) (
   input logic              wclk,
   input logic              rclk,
   input logic              rst_n,
   input logic              wen,
   input logic              ren,
   input logic              full,
   input logic              afull,
   input logic              empty,
   input logic              aempty,
   input logic [DATA_W-1:0] rdata,
   input logic [PTR_W-1:0]  wgray,
   input logic [PTR_W-1:0]  rgray
);
   // R2
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (full && wen) |=> $stable(wgray));

   // R3
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty && ren) |=> ($stable(rgray) && $stable(rdata)));

   // R5
   full_implies_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> afull);

   // R6
   empty_implies_aempty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |-> aempty);

   // R9
   wgray_one_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));

   // R9
   rgray_one_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      $onehot0(rgray ^ $past(rgray)));

   // R8
   reset_flags_chk: assert property (@(posedge wclk)
      !rst_n |-> (!full && !afull));
endmodule

bind dcx_fifo dcx_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen_i), .ren(ren_i),
   .full(full_o), .afull(afull_o), .empty(empty_o), .aempty(aempty_o),
   .rdata(rdata_o), .wgray(wgray), .rgray(rgray));

// File: tb/dcx_fifo_tb.sv
`timescale 1ns/1ps
module dcx_fifo_tb_top;
   logic        wclk = 1'b0, rclk_free = 1'b0, coin = 1'b0;
   logic        rclk;
   logic        rst_n = 1'b0;
   logic [5:0]  af_thr = '0, ae_thr = '0;
   logic        wen = 1'b0, ren = 1'b0;
   logic [35:0] wdata = '0;
   logic        full, afull, empty, aempty;
   logic [35:0] rdata;
   int          nchk = 0, nfail = 0;
   bit          done = 1'b0;

   always #2 wclk = ~wclk;
   always #3.5 rclk_free = ~rclk_free;
   assign rclk = coin ? wclk : rclk_free;

   dcx_fifo dut_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .af_thr_i(af_thr), .ae_thr_i(ae_thr),
      .wen_i(wen), .wdata_i(wdata), .full_o(full), .afull_o(afull),
      .ren_i(ren), .rdata_o(rdata), .empty_o(empty), .aempty_o(aempty));

   function automatic logic [35:0] pat(input int i);
      return {4'(i ^ 5), 32'h1357_0000 + 32'(i * 7)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [5:0] af, input logic [5:0] ae, input bit c);
      rst_n = 1'b0; wen = 1'b0; ren = 1'b0;
      coin = c; af_thr = af; ae_thr = ae;
      repeat (4) @(negedge wclk);
      repeat (4) @(negedge rclk);
      @(negedge wclk) rst_n = 1'b1;
      repeat (3) @(negedge wclk);
      repeat (3) @(negedge rclk);
   endtask

   task automatic settle();
      repeat (6) @(negedge wclk);
      repeat (6) @(negedge rclk);
   endtask

   task automatic write_n(input int start, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge wclk);
         wen = 1'b1; wdata = pat(start + k);
      end
      @(negedge wclk) wen = 1'b0;
   endtask

   task automatic read_chk(input int start, input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge rclk) ren = 1'b1;
         @(negedge rclk) ren = 1'b0;
         chk(rdata == pat(start + k), req, rdata, pat(start + k));
      end
   endtask

   // R8: flags while in reset and right after release
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge wclk);
      chk(empty && aempty && !full && !afull, "R8 in reset", {32'b0, empty, aempty, full, afull}, 36'hC);
      do_reset(6'd4, 6'd4, 1'b0);
      chk(empty, "R8 empty", empty, 1);
      chk(aempty, "R8 aempty", aempty, 1);
      chk(!full, "R8 full", full, 0);
      chk(!afull, "R8 afull", afull, 0);
   endtask

   // R5 R6 R4 with margins of 4
   task automatic t_margins();
      write_n(0, 4); settle();
      chk(!empty, "R6 empty at 4", empty, 0);
      chk(aempty, "R6 aempty at 4", aempty, 1);
      write_n(4, 1); settle();
      chk(!aempty, "R6 aempty at 5", aempty, 0);
      write_n(5, 54); settle();
      chk(!afull, "R5 afull at 59", afull, 0);
      write_n(59, 1); settle();
      chk(afull, "R5 afull at 60", afull, 1);
      write_n(60, 3); settle();
      chk(!full, "R4 full at 63", full, 0);
      write_n(63, 1); settle();
      chk(full, "R4 full at 64", full, 1);
   endtask

   // R2 R1 R4 R9: write while full, drain in order
   task automatic t_overflow();
      @(negedge wclk) begin wen = 1'b1; wdata = 36'hF_DEAD_BEEF; end
      @(negedge wclk) wen = 1'b0;
      settle();
      chk(full, "R2 still full", full, 1);
      read_chk(0, 64, "R1 R2 order");
      settle();
      chk(empty, "R6 empty after drain (R2 no extra word)", empty, 1);
      chk(!full, "R4 R9 full cleared", full, 0);
      chk(!afull, "R5 afull cleared", afull, 0);
   endtask

   // R3: read while empty
   task automatic t_underflow();
      @(negedge rclk) ren = 1'b1;
      @(negedge rclk) ren = 1'b0;
      chk(rdata == pat(63), "R3 rdata held", rdata, pat(63));
      chk(empty, "R3 still empty", empty, 1);
      write_n(100, 1); settle();
      read_chk(100, 1, "R3 pointer held");
   endtask

   // R7: zero selects default 8
   task automatic t_default();
      do_reset(6'd0, 6'd0, 1'b0);
      write_n(0, 8); settle();
      chk(aempty, "R7 aempty at 8", aempty, 1);
      write_n(8, 1); settle();
      chk(!aempty, "R7 aempty at 9", aempty, 0);
      write_n(9, 46); settle();
      chk(!afull, "R7 afull at 55", afull, 0);
      write_n(55, 1); settle();
      chk(afull, "R7 afull at 56", afull, 1);
   endtask

   // R10: same edge for both ports
   task automatic t_coincident();
      do_reset(6'd4, 6'd4, 1'b1);
      write_n(0, 6); settle();
      for (int i = 0; i < 24; i++) begin
         @(negedge wclk);
         if (i > 0) chk(rdata == pat(i - 1), "R10 stream", rdata, pat(i - 1));
         wen = 1'b1; ren = 1'b1; wdata = pat(6 + i);
      end
      @(negedge wclk);
      chk(rdata == pat(23), "R10 stream last", rdata, pat(23));
      wen = 1'b0; ren = 1'b0;
      settle();
      chk(!aempty && !empty, "R10 count kept", {34'b0, empty, aempty}, 36'h0);
      read_chk(24, 6, "R10 tail");
      settle();
      chk(empty, "R10 empty at end", empty, 1);
   endtask

   initial begin
      t_reset();
      t_margins();
      t_overflow();
      t_underflow();
      t_default();
      t_coincident();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #200us;
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule